// File: doc/BRIEF.md
# Standby Controller for HALT and HOLD

This block decides when a small microcontroller core executes instructions and when its oscillator runs. There are two low-power states. In the light state (HALT) instruction execution stops, but the clock, the 15-stage divider and the tenth-second timer keep running. Execution resumes when a release event occurs whose enable flag is set. In the deep state (HOLD) the oscillator is also stopped, and only a high level on an input pin can bring the core back. That pin's port must have had its release permission set beforehand.

Four events can end HALT. The divider chain wrapping past its all-ones value is one. A rising edge on port S or on port M is another; these are found by sampling each port on a divided strobe and comparing with the previous sample. The last is a periodic tenth-second pulse. Events that arrive while the core is running are dropped and are not stored. After a HOLD release, the oscillator is enabled at once, but the core stays stopped for a configurable number of clocks so the resonator can settle. An optional detector requests a system reset when all four S pins are high together. The core drives the command pulses, the flag write, and the divider clear.

State machine: `ST_RUN` → `ST_HALT` (halt_req) | `ST_HOLD` (hold_req, wins over halt_req); `ST_HALT` → `ST_RUN` (enabled wake event); `ST_HOLD` → `ST_SETTLE` (permitted port level high); `ST_SETTLE` → `ST_RUN` (settle count expired).

Top module: `standby_ctrl`

## Requirements
- R1: Reset puts the block in ST_RUN with cpu_run=1, osc_en=1, div_val=0 and sys_rst_req=0, and clears all four wake enables and both hold permissions, so after reset neither a port rise nor a port level ends a standby state.
- R2: In ST_RUN, a halt_req pulse (with hold_req low) gives cpu_run=0 and osc_en=1 from the next clock edge onward.
- R3: While osc_en=1 the divider div_val advances by one each clock and wraps modulo 2^DIV_STAGES. With wake enable bit 0 set, the cycle in which div_val is all ones ends ST_HALT at the following edge.
- R4: A div_clr pulse while the oscillator runs zeroes the upper CLR_BITS bits of div_val. The lower bits still advance by one, with no carry into the cleared bits.
- R5: Port S is sampled in cycles where the low SAMPLE_BITS bits of div_val are all ones. With wake enable bit 1 set, a sample with any bit that was 0 in the previous sample and is now 1 ends ST_HALT at that cycle's edge.
- R6: Port M is sampled and compared the same way. With wake enable bit 2 set, a 0-to-1 bit change ends ST_HALT.
- R7: A free-running counter emits one pulse every TENTH_LIMIT clocks while the oscillator runs. With wake enable bit 3 set, that pulse ends ST_HALT, so a halt lasts at most TENTH_LIMIT cycles.
- R8: Events whose wake enable bit is 0 leave the block in ST_HALT.
- R9: Events that occur while in ST_RUN are not stored. Entering ST_HALT afterwards waits for a fresh event.
- R10: hold_req in ST_RUN gives osc_en=0 and cpu_run=0 from the next edge, and div_val holds its value while osc_en=0.
- R11: ST_HOLD ends when any S pin is high with hold permission bit 0 set, or any M pin is high with permission bit 1 set. A high pin on a port without permission has no effect.
- R12: On leaving ST_HOLD the block enters ST_SETTLE, with osc_en=1 and cpu_run=0, for exactly SETTLE_CYCLES clocks before it returns to ST_RUN.
- R13: With S_RESET_EN=1, sys_rst_req is 1 in the cycle after one in which all S pins are high, and 0 in the cycle after any S pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (oscillator model) |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Enter light standby (one-cycle pulse) |
| hold_req | input | 1 | Enter deep standby (one-cycle pulse) |
| div_clr | input | 1 | Clear upper divider bits |
| cfg_wr | input | 1 | Load wake enables and hold permissions |
| cfg_wake_en | input | 4 | Bit0 divider wrap, bit1 S rise, bit2 M rise, bit3 tenth pulse |
| cfg_hold_perm | input | 2 | Bit0 S level, bit1 M level |
| port_s | input | PORT_W | Input port S |
| port_m | input | PORT_W | Input port M |
| cpu_run | output | 1 | 1 lets the core execute |
| osc_en | output | 1 | 1 keeps the oscillator running |
| div_val | output | DIV_STAGES | Divider count |
| sys_rst_req | output | 1 | System reset request from all S pins high |

## Verification
The properties assume that request pulses from the core are seen only in the state where they mean something, and that div_clr and flag writes are synchronous to clk. They also assume port pins hold steady long enough for the strobe to see each level. The stimulus pulses halt_req, hold_req, div_clr and cfg_wr for a single cycle, at a falling edge. It holds every port level for at least one sample interval before changing it again. Wake latencies are predicted from the div_val read at the moment of stimulus, and then compared when cpu_run rises.

// File: rtl/standby_pkg.sv
package standby_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_SETTLE = 2'd3
    } sb_state_e;

    localparam int SRC_OVF   = 0;
    localparam int SRC_SEDGE = 1;
    localparam int SRC_MEDGE = 2;
    localparam int SRC_TENTH = 3;
    localparam int NUM_SRC   = 4;

    localparam int PERM_S  = 0;
    localparam int PERM_M  = 1;
    localparam int NUM_PERM = 2;

endpackage

// File: rtl/sb_divider.sv
module sb_divider #(
    parameter int STAGES      = 15,
    parameter int CLR_BITS    = 4,
    parameter int TENTH_LIMIT = 45500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    output logic [STAGES-1:0] div_q,
    output logic              ovf,
    output logic              tenth
);
    localparam int LOW_BITS = STAGES - CLR_BITS;
    localparam int TW       = $clog2(TENTH_LIMIT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TENTH_LIMIT - 1);

    logic [TW-1:0] tcnt;

    // divider chain; a clear drops the upper stages and stops the carry into them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (run) begin
            if (clr) begin
                div_q[STAGES-1:LOW_BITS] <= '0;
                div_q[LOW_BITS-1:0]      <= div_q[LOW_BITS-1:0] + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    // tenth-second period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (run) begin
            if (tcnt == T_LAST) tcnt <= '0;
            else                tcnt <= tcnt + 1'b1;
        end
    end

    assign ovf   = run && (div_q == '1);
    assign tenth = run && (tcnt == T_LAST);

endmodule

// File: rtl/sb_edge_detect.sv
module sb_edge_detect #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [WIDTH-1:0] pin,
    output logic             rise
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (!rst_n)      prev <= '0;
        else if (strobe) prev <= pin;
    end

    assign rise = strobe && (|(pin & ~prev));

endmodule

// File: rtl/sb_fsm.sv
module sb_fsm
    import standby_pkg::*;
#(
    parameter int SETTLE_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic hold_req,
    input  logic wake,
    input  logic hold_release,
    output logic cpu_run,
    output logic osc_en
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] C_LAST = CW'(SETTLE_CYCLES - 1);

    sb_state_e     state, state_nx;
    logic [CW-1:0] settle_cnt;
    logic          settle_done;

    assign settle_done = (settle_cnt == C_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (hold_req)      state_nx = ST_HOLD;
                else if (halt_req) state_nx = ST_HALT;
            end
            ST_HALT:   if (wake)         state_nx = ST_RUN;
            ST_HOLD:   if (hold_release) state_nx = ST_SETTLE;
            ST_SETTLE: if (settle_done)  state_nx = ST_RUN;
            default:                     state_nx = ST_RUN;
        endcase
    end

    // oscillator settle counter, cleared outside ST_SETTLE
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_SETTLE) settle_cnt <= '0;
        else if (!settle_done)            settle_cnt <= settle_cnt + 1'b1;
    end

    // outputs
    always_comb begin
        cpu_run = 1'b0;
        osc_en  = 1'b1;
        unique case (state)
            ST_RUN:    cpu_run = 1'b1;
            ST_HALT:   osc_en  = 1'b1;
            ST_HOLD:   osc_en  = 1'b0;
            ST_SETTLE: osc_en  = 1'b1;
            default:   cpu_run = 1'b0;
        endcase
    end

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import standby_pkg::*;
#(
    parameter int DIV_STAGES    = 15,
    parameter int CLR_BITS      = 4,
    parameter int SAMPLE_BITS   = 3,
    parameter int TENTH_LIMIT   = 45500,
    parameter int SETTLE_CYCLES = 256,
    parameter int PORT_W        = 4,
    parameter bit S_RESET_EN    = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  halt_req,
    input  logic                  hold_req,
    input  logic                  div_clr,
    input  logic                  cfg_wr,
    input  logic [NUM_SRC-1:0]    cfg_wake_en,
    input  logic [NUM_PERM-1:0]   cfg_hold_perm,
    input  logic [PORT_W-1:0]     port_s,
    input  logic [PORT_W-1:0]     port_m,
    output logic                  cpu_run,
    output logic                  osc_en,
    output logic [DIV_STAGES-1:0] div_val,
    output logic                  sys_rst_req
);
    logic [NUM_SRC-1:0]  wake_en;
    logic [NUM_PERM-1:0] hold_perm;
    logic [NUM_SRC-1:0]  events;
    logic                strobe, wake, hold_release;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en   <= '0;
            hold_perm <= '0;
        end else if (cfg_wr) begin
            wake_en   <= cfg_wake_en;
            hold_perm <= cfg_hold_perm;
        end
    end

    sb_divider #(
        .STAGES     (DIV_STAGES),
        .CLR_BITS   (CLR_BITS),
        .TENTH_LIMIT(TENTH_LIMIT)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (osc_en),
        .clr  (div_clr),
        .div_q(div_val),
        .ovf  (events[SRC_OVF]),
        .tenth(events[SRC_TENTH])
    );

    assign strobe = osc_en && (&div_val[SAMPLE_BITS-1:0]);

    sb_edge_detect #(.WIDTH(PORT_W)) u_edge_s (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .pin(port_s), .rise(events[SRC_SEDGE])
    );

    sb_edge_detect #(.WIDTH(PORT_W)) u_edge_m (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .pin(port_m), .rise(events[SRC_MEDGE])
    );

    assign wake         = |(events & wake_en);
    assign hold_release = ((|port_s) && hold_perm[PERM_S]) ||
                          ((|port_m) && hold_perm[PERM_M]);

    sb_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_req    (halt_req),
        .hold_req    (hold_req),
        .wake        (wake),
        .hold_release(hold_release),
        .cpu_run     (cpu_run),
        .osc_en      (osc_en)
    );

    generate
        if (S_RESET_EN) begin : g_srst
            always_ff @(posedge clk) begin
                if (!rst_n) sys_rst_req <= 1'b0;
                else        sys_rst_req <= &port_s;
            end
        end else begin : g_nosrst
            assign sys_rst_req = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk #(
    parameter int DIV_STAGES = 15,
    parameter int CLR_BITS   = 4,
    parameter int PORT_W     = 4,
    parameter bit S_RESET_EN = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  halt_req,
    input logic                  hold_req,
    input logic                  div_clr,
    input logic [PORT_W-1:0]     port_s,
    input logic                  cpu_run,
    input logic                  osc_en,
    input logic [DIV_STAGES-1:0] div_val,
    input logic                  sys_rst_req
);
    localparam logic [DIV_STAGES-1:0] ONE = DIV_STAGES'(1);

    a_r1_run_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> osc_en);

    a_r2_halt_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && halt_req && !hold_req) |=> (!cpu_run && osc_en));

    a_r3_div_step: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !div_clr) |=> (div_val == $past(div_val) + ONE));

    a_r4_clear_top: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && div_clr) |=> (div_val[DIV_STAGES-1:DIV_STAGES-CLR_BITS] == '0));

    a_r10_hold_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && hold_req) |=> (!osc_en && !cpu_run));

    a_r10_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en) |=> (div_val == $past(div_val)));

    a_r12_no_direct_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en) |=> !cpu_run);

    generate
        if (S_RESET_EN) begin : g_srst
            a_r13_all_s_high: assert property (@(posedge clk) disable iff (!rst_n)
                (port_s == '1) |=> sys_rst_req);
            a_r13_any_s_low: assert property (@(posedge clk) disable iff (!rst_n)
                (port_s != '1) |=> !sys_rst_req);
        end
    endgenerate

endmodule

bind standby_ctrl standby_ctrl_chk #(
    .DIV_STAGES(DIV_STAGES),
    .CLR_BITS  (CLR_BITS),
    .PORT_W    (PORT_W),
    .S_RESET_EN(S_RESET_EN)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req   (halt_req),
    .hold_req   (hold_req),
    .div_clr    (div_clr),
    .port_s     (port_s),
    .cpu_run    (cpu_run),
    .osc_en     (osc_en),
    .div_val    (div_val),
    .sys_rst_req(sys_rst_req)
);

// File: tb/standby_ctrl_tb_top.sv
module standby_ctrl_tb_top;
    localparam int DS    = 10;
    localparam int SB    = 2;
    localparam int TL    = 700;
    localparam int SC    = 16;
    localparam int DMAX  = 1 << DS;
    localparam int SMASK = (1 << SB) - 1;
    localparam int LOWM  = (1 << (DS - 4)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt_req = 1'b0, hold_req = 1'b0, div_clr = 1'b0, cfg_wr = 1'b0;
    logic [3:0]    cfg_wake_en = '0;
    logic [1:0]    cfg_hold_perm = '0;
    logic [3:0]    port_s = '0, port_m = '0;
    logic          cpu_run, osc_en, sys_rst_req;
    logic [DS-1:0] div_val;

    always #5 clk = ~clk;

    standby_ctrl #(
        .DIV_STAGES(DS), .CLR_BITS(4), .SAMPLE_BITS(SB), .TENTH_LIMIT(TL),
        .SETTLE_CYCLES(SC), .PORT_W(4), .S_RESET_EN(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .hold_req(hold_req),
        .div_clr(div_clr), .cfg_wr(cfg_wr), .cfg_wake_en(cfg_wake_en),
        .cfg_hold_perm(cfg_hold_perm), .port_s(port_s), .port_m(port_m),
        .cpu_run(cpu_run), .osc_en(osc_en), .div_val(div_val), .sys_rst_req(sys_rst_req)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    int    low_cnt = 0;
    int    mon_e;
    string mon_t;
    int    d;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard: expected stopped-cycle count (negative = upper bound)
    task automatic push_exp(input string tag, input int lat);
        tag_q.push_back(tag);
        exp_q.push_back(lat);
    endtask

    // monitor: counts sampled cycles with cpu_run low, compares on each return to run
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cpu_run) begin
                low_cnt++;
            end else begin
                if (low_cnt > 0 && exp_q.size() > 0) begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    if (mon_e < 0) chk(mon_t, int'(low_cnt <= -mon_e), 1);
                    else           chk(mon_t, low_cnt, mon_e);
                end
                low_cnt = 0;
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; port_s = '0; port_m = '0;
        halt_req = 0; hold_req = 0; div_clr = 0; cfg_wr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(input logic [3:0] we, input logic [1:0] hp);
        cfg_wake_en = we; cfg_hold_perm = hp; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic go_halt(input int h);
        halt_req = 1'b1;
        repeat (h) begin
            @(negedge clk);
            halt_req = 1'b0;
        end
    endtask

    task automatic wait_run(input string tag, input int lim);
        int n = 0;
        while (!cpu_run && n < lim) begin
            @(negedge clk);
            n++;
        end
        chk(tag, cpu_run, 1);
        @(negedge clk);
    endtask

    function automatic int samp_wait(input int dv);
        return (SMASK - (dv & SMASK)) & SMASK;
    endfunction

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 cpu_run", cpu_run, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 div_val", int'(div_val), 0);
        chk("R1 sys_rst_req", sys_rst_req, 0);

        // R3 divider step
        d = int'(div_val);
        @(negedge clk);
        chk("R3 div step", int'(div_val), (d + 1) % DMAX);

        // R4 clear of upper stages
        repeat (200) @(negedge clk);
        d = int'(div_val);
        div_clr = 1'b1;
        @(negedge clk);
        div_clr = 1'b0;
        chk("R4 div clear", int'(div_val), ((d & LOWM) + 1) & LOWM);

        // R3 divider wrap wake, R2 halt entry
        cfg(4'b0001, 2'b00);
        d = int'(div_val);
        push_exp("R3 wrap wake latency", ((2 * DMAX - 2 - d) % DMAX) + 1);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
        chk("R2 cpu_run low", cpu_run, 0);
        chk("R2 osc_en high", osc_en, 1);
        wait_run("R3 wrap wake", DMAX + 10);

        // R5 port S rising edge
        cfg(4'b0010, 2'b00);
        go_halt(12);
        d = int'(div_val);
        push_exp("R5 S edge latency", 12 + samp_wait(d));
        port_s = 4'b0001;
        wait_run("R5 S edge wake", 40);

        // R6 port M rising edge
        cfg(4'b0100, 2'b00);
        go_halt(9);
        d = int'(div_val);
        push_exp("R6 M edge latency", 9 + samp_wait(d));
        port_m = 4'b1000;
        wait_run("R6 M edge wake", 40);

        // R9 rise while running is dropped
        cfg(4'b0010, 2'b00);
        port_s = 4'b0000;
        repeat (8) @(negedge clk);
        port_s = 4'b0011;
        repeat (8) @(negedge clk);
        go_halt(10);
        port_s = 4'b0000;
        repeat (10) @(negedge clk);
        d = int'(div_val);
        push_exp("R9 no stored event latency", 20 + samp_wait(d));
        port_s = 4'b0100;
        wait_run("R9 fresh event wake", 40);

        // R7 tenth-second pulse
        port_s = '0; port_m = '0;
        cfg(4'b1000, 2'b00);
        push_exp("R7 tenth bound", -TL);
        go_halt(1);
        wait_run("R7 tenth wake", TL + 10);

        // R8 disabled sources
        cfg(4'b0000, 2'b00);
        go_halt(5);
        port_s = 4'b0001; port_m = 4'b0001;
        repeat (DMAX + TL) @(negedge clk);
        chk("R8 stays halted", cpu_run, 0);
        do_reset();
        chk("R1 reset exits halt", cpu_run, 1);

        // R1 flags cleared by reset
        cfg(4'b1111, 2'b11);
        do_reset();
        go_halt(4);
        port_s = 4'b0010; port_m = 4'b0010;
        repeat (40) @(negedge clk);
        chk("R1 enables cleared", cpu_run, 0);
        do_reset();

        // R10 R11 R12 deep standby
        cfg(4'b0000, 2'b01);
        hold_req = 1'b1;
        @(negedge clk);
        hold_req = 1'b0;
        chk("R10 osc_en off", osc_en, 0);
        chk("R10 cpu_run off", cpu_run, 0);
        d = int'(div_val);
        repeat (10) @(negedge clk);
        chk("R10 divider frozen", int'(div_val), d);
        port_m = 4'b0010;
        repeat (10) @(negedge clk);
        chk("R11 M without permission", osc_en, 0);
        push_exp("R12 hold plus settle latency", 21 + SC);
        port_s = 4'b0100;
        @(negedge clk);
        chk("R12 settle osc_en", osc_en, 1);
        chk("R12 settle cpu_run", cpu_run, 0);
        wait_run("R11 S level release", SC + 10);
        port_s = '0; port_m = '0;

        // R13 all S pins high
        repeat (2) @(negedge clk);
        port_s = 4'hF;
        @(negedge clk);
        chk("R13 reset request", sys_rst_req, 1);
        port_s = 4'h7;
        @(negedge clk);
        chk("R13 request drops", sys_rst_req, 0);
        port_s = 4'h0;

        repeat (2) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule